// File: doc/BRIEF.md
# Two-Thread Congestion Throttle

This block watches two hardware threads that share one out-of-order core. It flags a thread as congested when the thread has too many outstanding long-latency misses or holds too many reorder-buffer entries. It then throttles that thread in steps of increasing force. The first step lowers the thread's decode priority. The second step stops its decode. The third step also pulses a request that discards the thread's instructions waiting for dispatch.

Each step lasts for a programmable number of congested cycles before the block moves to the next one. The throttle releases only when every monitored count has dropped below a separate, lower release threshold. Only one thread is throttled at a time.

The block also drives the decode-slot grant. Each thread receives a share of decode cycles in proportion to its priority level. A thread whose decode is blocked receives no cycles.

Top module: `smt_throttle_unit`

## Requirements
- R1: A thread is congested when its L2 load-miss count plus its TLB-miss count is greater than or equal to `miss_hi_thr_i`, or when its reorder-buffer occupancy is greater than or equal to `rob_hi_thr_i`.
- R2: When no thread is throttled and at least one thread is congested, one thread becomes throttled at the next clock edge. If both threads are congested, the thread with the larger occupancy is chosen; on a tie, thread 0 is chosen.
- R3: At most one thread is throttled at any time. While a thread is throttled, congestion in the other thread has no effect.
- R4: The level advances (priority, then decode stop, then flush) after the throttled thread has been congested for `dwell_i` consecutive cycles at the current level; a value of 0 counts as 1. A cycle that is neither congested nor released keeps the level and restarts the count.
- R5: At every throttle level, the throttled thread's `prio_o` equals LOW_PRIO (1). An unthrottled thread's `prio_o` equals NORM_PRIO (4).
- R6: At the decode-stop level and at the flush level, `decode_inhibit_o` is high for the throttled thread.
- R7: `flush_o` is high for the throttled thread for exactly one cycle, in the first cycle of the flush level. It stays low for as long as the thread remains at that level.
- R8: The throttle releases at the next edge once the throttled thread's miss sum is below `miss_lo_thr_i` and its occupancy is below `rob_lo_thr_i`. Release takes precedence over escalation.
- R9: Decode grants repeat in frames of prio0+prio1 cycles. Thread 0 is granted the first prio0 cycles of each frame and thread 1 the rest. Exactly one bit of `decode_grant_o` is set in every cycle, and a thread with its decode stopped is never granted.
- R10: Reset, at any time, returns the block to the unthrottled state with both priorities at NORM_PRIO and the frame at its first slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l2_miss_cnt_i | input | 2 x CNT_W | Outstanding L2 load misses per thread |
| tlb_miss_cnt_i | input | 2 x CNT_W | Outstanding TLB misses per thread |
| rob_occ_i | input | 2 x ROB_W | Reorder-buffer entries held per thread |
| miss_hi_thr_i | input | CNT_W+1 | Miss-sum level that marks congestion |
| miss_lo_thr_i | input | CNT_W+1 | Miss sum must fall below this to release |
| rob_hi_thr_i | input | ROB_W | Occupancy level that marks congestion |
| rob_lo_thr_i | input | ROB_W | Occupancy must fall below this to release |
| dwell_i | input | DWELL_W | Congested cycles spent per level before escalating |
| prio_o | output | 2 x PRIO_W | Decode priority per thread |
| decode_inhibit_o | output | 2 | Decode stopped, per thread |
| flush_o | output | 2 | One-cycle request to flush dispatch-waiting instructions |
| decode_grant_o | output | 2 | One-hot decode slot owner this cycle |

## Verification
The bench builds the block with its default parameters: 6-bit miss counts, 7-bit occupancy, an 8-bit dwell and 3-bit priorities. With these, the frame is 8 cycles when no thread is throttled and 5 cycles when one is. Because `dwell_i` is a port, the bench changes it while running. A dwell of 3 lets the vector table walk a full escalation with an interruption in the hysteresis band. A dwell of 200 holds a level steady long enough to count decode shares over whole frames. A dwell of 1 forces the single flush pulse at once.

// File: rtl/smt_thr_pkg.sv
package smt_thr_pkg;

  typedef enum logic [1:0] {
    LVL_NONE    = 2'd0,
    LVL_PRIO    = 2'd1,
    LVL_INHIBIT = 2'd2,
    LVL_FLUSH   = 2'd3
  } thr_lvl_e;

endpackage

// File: rtl/smt_cong_detect.sv
module smt_cong_detect #(
  parameter int CNT_W = 6,
  parameter int ROB_W = 7
) (
  input  logic [CNT_W-1:0] l2_i,
  input  logic [CNT_W-1:0] tlb_i,
  input  logic [ROB_W-1:0] rob_i,
  input  logic [CNT_W:0]   miss_hi_i,
  input  logic [CNT_W:0]   miss_lo_i,
  input  logic [ROB_W-1:0] rob_hi_i,
  input  logic [ROB_W-1:0] rob_lo_i,
  output logic             hot_o,
  output logic             cool_o
);

  logic [CNT_W:0] miss_sum;

  assign miss_sum = {1'b0, l2_i} + {1'b0, tlb_i};
  assign hot_o    = (miss_sum >= miss_hi_i) || (rob_i >= rob_hi_i);
  assign cool_o   = (miss_sum <  miss_lo_i) && (rob_i <  rob_lo_i);

endmodule

// File: rtl/smt_throttle_ctrl.sv
module smt_throttle_ctrl
  import smt_thr_pkg::*;
#(
  parameter int ROB_W   = 7,
  parameter int DWELL_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            hot_i,
  input  logic [1:0]            cool_i,
  input  logic [1:0][ROB_W-1:0] rob_i,
  input  logic [DWELL_W-1:0]    dwell_i,
  output logic [1:0]            low_o,
  output logic [1:0]            inhibit_o,
  output logic [1:0]            flush_o
);

  localparam int CW = DWELL_W + 1;

  thr_lvl_e           lvl_q, lvl_d;
  logic               vic_q, vic_d;
  logic [DWELL_W-1:0] cnt_q, cnt_d;
  logic               flush_q;
  logic               pick;
  logic               dwell_done;

  // both congested: larger occupancy wins, tie to thread 0
  assign pick       = (hot_i[0] && hot_i[1]) ? (rob_i[1] > rob_i[0]) : hot_i[1];
  assign dwell_done = ({1'b0, cnt_q} + CW'(1)) >= {1'b0, dwell_i};

  always_comb begin
    lvl_d = lvl_q;
    vic_d = vic_q;
    cnt_d = cnt_q;
    if (lvl_q == LVL_NONE) begin
      if (|hot_i) begin
        lvl_d = LVL_PRIO;
        vic_d = pick;
        cnt_d = '0;
      end
    end else if (cool_i[vic_q]) begin
      lvl_d = LVL_NONE;
      cnt_d = '0;
    end else if (hot_i[vic_q]) begin
      if (lvl_q != LVL_FLUSH) begin
        if (dwell_done) begin
          lvl_d = (lvl_q == LVL_PRIO) ? LVL_INHIBIT : LVL_FLUSH;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + DWELL_W'(1);
        end
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= LVL_NONE;
      vic_q   <= 1'b0;
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_d;
      vic_q   <= vic_d;
      cnt_q   <= cnt_d;
      flush_q <= (lvl_d == LVL_FLUSH) && (lvl_q != LVL_FLUSH);
    end
  end

  for (genvar t = 0; t < 2; t++) begin : g_out
    logic is_vic;
    assign is_vic       = (vic_q == 1'(t));
    assign low_o[t]     = is_vic && (lvl_q != LVL_NONE);
    assign inhibit_o[t] = is_vic && ((lvl_q == LVL_INHIBIT) || (lvl_q == LVL_FLUSH));
    assign flush_o[t]   = is_vic && flush_q;
  end

  // R3
  one_victim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(low_o));

  // R2
  engage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q == LVL_NONE && |hot_i) |=> (|low_o));

  // R8
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != LVL_NONE && cool_i[vic_q]) |=> (low_o == 2'b00));

  // R7
  flush_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flush_o) |=> !(|flush_o));

  // R7
  flush_inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o & ~inhibit_o) == 2'b00);

  // R6
  inhibit_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_o & ~low_o) == 2'b00);

endmodule

// File: rtl/smt_decode_share.sv
module smt_decode_share #(
  parameter int PRIO_W    = 3,
  parameter int NORM_PRIO = 4,
  parameter int LOW_PRIO  = 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             low_i,
  input  logic [1:0]             inhibit_i,
  output logic [1:0][PRIO_W-1:0] prio_o,
  output logic [1:0]             grant_o
);

  localparam int SUM_W = PRIO_W + 1;

  logic [SUM_W-1:0] slot_q, slot_d, frame_len;

  for (genvar t = 0; t < 2; t++) begin : g_prio
    assign prio_o[t] = low_i[t] ? PRIO_W'(LOW_PRIO) : PRIO_W'(NORM_PRIO);
  end

  assign frame_len = {1'b0, prio_o[0]} + {1'b0, prio_o[1]};
  // wrap also covers a frame that shrank mid-way
  assign slot_d    = (slot_q >= frame_len - SUM_W'(1)) ? '0 : slot_q + SUM_W'(1);

  always_comb begin
    if (inhibit_i[0])                     grant_o = 2'b10;
    else if (inhibit_i[1])                grant_o = 2'b01;
    else if (slot_q < {1'b0, prio_o[0]})  grant_o = 2'b01;
    else                                  grant_o = 2'b10;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_d;
  end

  // R9
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant_o) == 1);

  // R9
  inhibit_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & inhibit_i) == 2'b00);

endmodule

// File: rtl/smt_throttle_unit.sv
module smt_throttle_unit #(
  parameter int CNT_W     = 6,
  parameter int ROB_W     = 7,
  parameter int DWELL_W   = 8,
  parameter int PRIO_W    = 3,
  parameter int NORM_PRIO = 4,
  parameter int LOW_PRIO  = 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0][CNT_W-1:0]  l2_miss_cnt_i,
  input  logic [1:0][CNT_W-1:0]  tlb_miss_cnt_i,
  input  logic [1:0][ROB_W-1:0]  rob_occ_i,
  input  logic [CNT_W:0]         miss_hi_thr_i,
  input  logic [CNT_W:0]         miss_lo_thr_i,
  input  logic [ROB_W-1:0]       rob_hi_thr_i,
  input  logic [ROB_W-1:0]       rob_lo_thr_i,
  input  logic [DWELL_W-1:0]     dwell_i,
  output logic [1:0][PRIO_W-1:0] prio_o,
  output logic [1:0]             decode_inhibit_o,
  output logic [1:0]             flush_o,
  output logic [1:0]             decode_grant_o
);

  logic [1:0] hot, cool, low;

  for (genvar t = 0; t < 2; t++) begin : g_det
    smt_cong_detect #(
      .CNT_W(CNT_W),
      .ROB_W(ROB_W)
    ) i_det (
      .l2_i     (l2_miss_cnt_i[t]),
      .tlb_i    (tlb_miss_cnt_i[t]),
      .rob_i    (rob_occ_i[t]),
      .miss_hi_i(miss_hi_thr_i),
      .miss_lo_i(miss_lo_thr_i),
      .rob_hi_i (rob_hi_thr_i),
      .rob_lo_i (rob_lo_thr_i),
      .hot_o    (hot[t]),
      .cool_o   (cool[t])
    );
  end

  smt_throttle_ctrl #(
    .ROB_W  (ROB_W),
    .DWELL_W(DWELL_W)
  ) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hot_i    (hot),
    .cool_i   (cool),
    .rob_i    (rob_occ_i),
    .dwell_i  (dwell_i),
    .low_o    (low),
    .inhibit_o(decode_inhibit_o),
    .flush_o  (flush_o)
  );

  smt_decode_share #(
    .PRIO_W   (PRIO_W),
    .NORM_PRIO(NORM_PRIO),
    .LOW_PRIO (LOW_PRIO)
  ) i_share (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .low_i    (low),
    .inhibit_i(decode_inhibit_o),
    .prio_o   (prio_o),
    .grant_o  (decode_grant_o)
  );

endmodule

// File: tb/test_smt_throttle_unit.sv
module test_smt_throttle_unit;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0][5:0]  l2, tlb;
  logic [1:0][6:0]  rob;
  logic [7:0]       dwell;
  logic [1:0][2:0]  prio;
  logic [1:0]       inh, fl, gnt;
  int               n_chk = 0;
  int               n_bad = 0;
  bit               done = 1'b0;

  always #5 clk = ~clk;

  smt_throttle_unit i_smt_throttle_unit (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .l2_miss_cnt_i   (l2),
    .tlb_miss_cnt_i  (tlb),
    .rob_occ_i       (rob),
    .miss_hi_thr_i   (7'd8),
    .miss_lo_thr_i   (7'd4),
    .rob_hi_thr_i    (7'd48),
    .rob_lo_thr_i    (7'd32),
    .dwell_i         (dwell),
    .prio_o          (prio),
    .decode_inhibit_o(inh),
    .flush_o         (fl),
    .decode_grant_o  (gnt)
  );

  // {l2_0,tlb_0,rob_0, l2_1,tlb_1,rob_1, low_exp, inh_exp, flush_exp}
  localparam int NV = 23;
  localparam logic [43:0] VECS [NV] = '{
    {6'd0, 6'd0,7'd10, 6'd0, 6'd0,7'd10, 2'b00,2'b00,2'b00}, // idle
    {6'd5, 6'd3,7'd10, 6'd0, 6'd0,7'd10, 2'b01,2'b00,2'b00}, // R1 R2 sum hits 8
    {6'd5, 6'd3,7'd10, 6'd0, 6'd0,7'd10, 2'b01,2'b00,2'b00}, // R4
    {6'd5, 6'd3,7'd10, 6'd0, 6'd0,7'd10, 2'b01,2'b00,2'b00},
    {6'd5, 6'd3,7'd10, 6'd0, 6'd0,7'd10, 2'b01,2'b01,2'b00}, // R6
    {6'd6, 6'd0,7'd10, 6'd0, 6'd0,7'd10, 2'b01,2'b01,2'b00}, // R4 band
    {6'd9, 6'd0,7'd10, 6'd0, 6'd0,7'd10, 2'b01,2'b01,2'b00},
    {6'd9, 6'd0,7'd10, 6'd0, 6'd0,7'd10, 2'b01,2'b01,2'b00},
    {6'd9, 6'd0,7'd10, 6'd0, 6'd0,7'd10, 2'b01,2'b01,2'b01}, // R7
    {6'd9, 6'd0,7'd10, 6'd0, 6'd0,7'd10, 2'b01,2'b01,2'b00}, // R7
    {6'd3, 6'd0,7'd40, 6'd0, 6'd0,7'd10, 2'b01,2'b01,2'b00}, // R8 rob blocks release
    {6'd3, 6'd0,7'd20, 6'd0, 6'd0,7'd10, 2'b00,2'b00,2'b00}, // R8
    {6'd0, 6'd0,7'd10, 6'd0, 6'd0,7'd50, 2'b10,2'b00,2'b00}, // R1 rob
    {6'd10,6'd0,7'd10, 6'd0, 6'd0,7'd50, 2'b10,2'b00,2'b00}, // R3
    {6'd10,6'd0,7'd10, 6'd0, 6'd0,7'd10, 2'b00,2'b00,2'b00}, // R8
    {6'd0,6'd10,7'd20, 6'd0, 6'd0,7'd10, 2'b01,2'b00,2'b00}, // R1 tlb
    {6'd0, 6'd0,7'd10, 6'd0, 6'd0,7'd10, 2'b00,2'b00,2'b00},
    {6'd9, 6'd0,7'd40, 6'd0, 6'd0,7'd60, 2'b10,2'b00,2'b00}, // R2 both
    {6'd0, 6'd0,7'd10, 6'd0, 6'd0,7'd10, 2'b00,2'b00,2'b00},
    {6'd0, 6'd0,7'd55, 6'd12,6'd0,7'd30, 2'b01,2'b00,2'b00}, // R2 both
    {6'd0, 6'd0,7'd10, 6'd0, 6'd0,7'd10, 2'b00,2'b00,2'b00},
    {6'd0, 6'd0,7'd50, 6'd0, 6'd0,7'd50, 2'b01,2'b00,2'b00}, // R2 tie
    {6'd0, 6'd0,7'd10, 6'd0, 6'd0,7'd10, 2'b00,2'b00,2'b00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  task automatic set_in(input logic [43:0] v);
    l2[0] = v[43:38]; tlb[0] = v[37:32]; rob[0] = v[31:25];
    l2[1] = v[24:19]; tlb[1] = v[18:13]; rob[1] = v[12:6];
  endtask

  task automatic count_grants(input int n, output int c0, output int c1);
    c0 = 0; c1 = 0;
    for (int i = 0; i < n; i++) begin
      c0 += int'(gnt[0]);
      c1 += int'(gnt[1]);
      @(negedge clk);
    end
  endtask

  task automatic quiet;
    set_in({6'd0,6'd0,7'd10,6'd0,6'd0,7'd10,6'd0});
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int c0, c1, nf0, nf1;
    logic [1:0] lowv;
    quiet();
    dwell = 8'd3;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk(prio[0] == 3'd4 && prio[1] == 3'd4, "R10 prio", prio, 36);
    chk(inh == 2'b00 && fl == 2'b00, "R10 inh/flush", {inh, fl}, 0);
    chk(gnt == 2'b01, "R10 grant", gnt, 1);

    for (int k = 0; k < NV; k++) begin
      set_in(VECS[k]);
      @(negedge clk);
      lowv = {prio[1] == 3'd1, prio[0] == 3'd1};
      chk(lowv == VECS[k][5:4], $sformatf("R5 vec%0d low", k), lowv, VECS[k][5:4]);
      chk(inh == VECS[k][3:2], $sformatf("R6 vec%0d inhibit", k), inh, VECS[k][3:2]);
      chk(fl == VECS[k][1:0], $sformatf("R7 vec%0d flush", k), fl, VECS[k][1:0]);
    end

    // R9 even split when unthrottled
    quiet();
    repeat (10) @(negedge clk);
    count_grants(40, c0, c1);
    chk(c0 == 20, "R9 share t0 normal", c0, 20);
    chk(c1 == 20, "R9 share t1 normal", c1, 20);

    // R5 R9 thread 0 at priority level
    dwell = 8'd200;
    l2[0] = 6'd9;
    repeat (10) @(negedge clk);
    chk(prio[0] == 3'd1, "R5 prio t0 low", prio[0], 1);
    chk(prio[1] == 3'd4, "R5 prio t1 normal", prio[1], 4);
    count_grants(40, c0, c1);
    chk(c0 == 8, "R9 share t0 low", c0, 8);
    chk(c1 == 32, "R9 share t1 high", c1, 32);

    // R4 R6 dwell of one escalates next edge
    dwell = 8'd1;
    @(negedge clk);
    dwell = 8'd200;
    chk(inh == 2'b01, "R6 inhibit t0", inh, 1);
    chk(fl == 2'b00, "R7 no flush before level", fl, 0);
    repeat (10) @(negedge clk);
    count_grants(40, c0, c1);
    chk(c0 == 0, "R9 inhibited t0 no grant", c0, 0);
    chk(c1 == 40, "R9 t1 all grants", c1, 40);

    // R7 one pulse per escalation while level is held
    dwell = 8'd1;
    nf0 = 0; nf1 = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      nf0 += int'(fl[0]);
      nf1 += int'(fl[1]);
    end
    chk(nf0 == 1, "R7 flush pulses t0", nf0, 1);
    chk(nf1 == 0, "R7 flush pulses t1", nf1, 0);
    chk(inh == 2'b01, "R7 inhibit held at flush", inh, 1);

    // R8 release
    quiet();
    @(negedge clk);
    chk(inh == 2'b00 && prio[0] == 3'd4, "R8 released", {inh, prio[0]}, 4);

    // R10 reset mid-throttle
    dwell = 8'd3;
    l2[0] = 6'd9;
    repeat (6) @(negedge clk);
    chk(inh == 2'b01, "R4 escalated before reset", inh, 1);
    rst_n = 1'b0;
    #1;
    chk(inh == 2'b00 && fl == 2'b00, "R10 mid reset inh/flush", {inh, fl}, 0);
    chk(prio[0] == 3'd4 && prio[1] == 3'd4, "R10 mid reset prio", prio, 36);
    chk(gnt == 2'b01, "R10 mid reset grant", gnt, 1);
    quiet();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
    end
  end

endmodule